// File: doc/BRIEF.md
# Hotspot-Driven Cartridge Bank Mapper

This block maps a 4K cartridge window on an 8-bit CPU bus onto a larger ROM image and a separate banked RAM. Only the low 13 address bits reach it. Address bit 12 set means the access falls in the window. A byte written to one of two low-memory hotspot addresses reprograms the mapping.

The written byte carries two fields. Its upper two bits name a destination segment and its lower six bits name a bank. A ROM switch places a 1K ROM bank into one of four 1K segments. A RAM switch places a 512-byte RAM bank into one of four 512-byte read slots in the lower half of the window. Each RAM slot has a write port mirrored 0x800 above it.

The mapper keeps an eight-entry table, one entry per 512-byte slot. Each entry holds a content type and a bank number. Every access is resolved through this table into either a ROM image address or a RAM address, together with select strobes, a RAM write enable and a multiplexed read byte. The ROM and RAM storage sit outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, slots 6 and 7 (addresses 0x1C00-0x1FFF) read ROM bank 0, so reading 0x1C05 asserts rom_sel with rom_addr 0x0005. Every other slot is undefined.
- R2: An access with cpu_addr[12]=0 asserts neither rom_sel nor ram_sel, and ram_we stays low.
- R3: A write (cpu_wr=1) to 0x003F with data {s[1:0], b[5:0]} maps ROM bank b into both slots of 1K segment s (slots 2s and 2s+1) from the next clock edge. A read there gives rom_addr = {b, cpu_addr[9:0]}.
- R4: A write to 0x003E with data {s[1:0], b[5:0]} maps RAM bank b into slot s only. A read there asserts ram_sel with ram_addr = {b, cpu_addr[8:0]}, and the other half of the same 1K segment keeps its ROM mapping.
- R5: A ROM switch to a segment replaces any RAM mapping in either of its slots.
- R6: A write to 0x1800 + n*0x200 + offset, where slot n (0-3) holds RAM bank b, asserts ram_sel and ram_we with ram_addr = {b, offset[8:0]}.
- R7: A write in the window is ignored (no select, no ram_we) when it falls below 0x1800, or when the read slot matching its mirror does not hold RAM.
- R8: A read in 0x1800-0x1FFF is resolved through the slot table for that address, not through the write mirror.
- R9: A write to any address other than the two hotspots leaves the mapping unchanged.
- R10: A read of an undefined slot, or any access without a select, drives cpu_rdata = 0xFF.
- R11: During a read, cpu_rdata equals rom_rdata when rom_sel is high and ram_rdata when ram_sel is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; hotspot writes update the mapping on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 13 | CPU address, low 13 bits |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | High for a write cycle, low for a read |
| cpu_rdata | output | 8 | Read byte returned to the CPU |
| rom_rdata | input | 8 | Byte from the external ROM |
| ram_rdata | input | 8 | Byte from the external RAM |
| rom_addr | output | 16 | ROM image address |
| rom_sel | output | 1 | ROM read select |
| ram_addr | output | 15 | RAM address |
| ram_sel | output | 1 | RAM select, for read or write |
| ram_we | output | 1 | RAM write enable |

## Verification
The assertions assume that cpu_addr, cpu_wr and cpu_wdata are steady around each rising clock edge, and that a hotspot write lasts one clock cycle. The bench changes inputs only on falling edges and holds each vector for exactly one cycle, so every hotspot write is seen by exactly one rising edge. Random traffic mixes the following:
- hotspot writes with random segment and bank fields,
- reads and writes across the whole window,
- writes outside the window.

Directed steps cover the reset map, the partial hiding of a ROM segment by RAM, and the behaviour of the write mirror.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter logic [12:0] ROM_HOT = 13'h003F,
  parameter logic [12:0] RAM_HOT = 13'h003E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  output logic [7:0]  cpu_rdata,
  input  logic [7:0]  rom_rdata,
  input  logic [7:0]  ram_rdata,
  output logic [15:0] rom_addr,
  output logic        rom_sel,
  output logic [14:0] ram_addr,
  output logic        ram_sel,
  output logic        ram_we
);
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_ROM  = 2'd1;
  localparam logic [1:0] K_RAM  = 2'd2;

  logic [7:0][1:0] kind_q;
  logic [7:0][5:0] bank_q;

  wire [1:0] seg = cpu_wdata[7:6];
  wire [5:0] bnk = cpu_wdata[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        kind_q[i] <= (i >= 6) ? K_ROM : K_NONE;
        bank_q[i] <= '0;
      end
    end else if (cpu_wr) begin
      if (cpu_addr == ROM_HOT) begin
        kind_q[{seg, 1'b0}] <= K_ROM;
        kind_q[{seg, 1'b1}] <= K_ROM;
        bank_q[{seg, 1'b0}] <= bnk;
        bank_q[{seg, 1'b1}] <= bnk;
      end else if (cpu_addr == RAM_HOT) begin
        kind_q[{1'b0, seg}] <= K_RAM;
        bank_q[{1'b0, seg}] <= bnk;
      end
    end
  end

  wire       in_win  = cpu_addr[12];
  wire [2:0] rd_slot = cpu_addr[11:9];
  wire [2:0] wr_slot = {1'b0, cpu_addr[10:9]};
  wire       rd_rom  = in_win & ~cpu_wr & (kind_q[rd_slot] == K_ROM);
  wire       rd_ram  = in_win & ~cpu_wr & (kind_q[rd_slot] == K_RAM);
  wire       wr_ram  = in_win & cpu_wr & cpu_addr[11] & (kind_q[wr_slot] == K_RAM);

  assign rom_sel   = rd_rom;
  assign ram_sel   = rd_ram | wr_ram;
  assign ram_we    = wr_ram;
  assign rom_addr  = {bank_q[rd_slot], cpu_addr[9:0]};
  assign ram_addr  = {bank_q[cpu_wr ? wr_slot : rd_slot], cpu_addr[8:0]};
  assign cpu_rdata = rd_rom ? rom_rdata : (rd_ram ? ram_rdata : 8'hFF);

  a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[12] |-> (!rom_sel && !ram_sel && !ram_we));

  a_r3_rom_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == ROM_HOT) |=>
      (kind_q[{$past(cpu_wdata[7:6]), 1'b1}] == K_ROM &&
       bank_q[{$past(cpu_wdata[7:6]), 1'b0}] == $past(cpu_wdata[5:0])));

  a_r4_ram_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == RAM_HOT) |=>
      (kind_q[{1'b0, $past(cpu_wdata[7:6])}] == K_RAM &&
       bank_q[{1'b0, $past(cpu_wdata[7:6])}] == $past(cpu_wdata[5:0])));

  a_r7_write_in_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && cpu_addr[12] && cpu_addr[11]));

  a_r9_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && (cpu_addr == ROM_HOT || cpu_addr == RAM_HOT)) |=>
      ($stable(kind_q) && $stable(bank_q)));

  a_r10_blank_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel && !ram_sel) |-> (cpu_rdata == 8'hFF));
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, rom_rdata = '0, ram_rdata = '0;
  logic [15:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_sel, ram_sel, ram_we;

  int vectors = 0;
  int errors = 0;
  int mkind [8];
  int mbank [8];

  always #5 clk = ~clk;

  cart_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_rdata(rom_rdata),
    .ram_rdata(ram_rdata), .rom_addr(rom_addr), .rom_sel(rom_sel),
    .ram_addr(ram_addr), .ram_sel(ram_sel), .ram_we(ram_we)
  );

  function automatic logic [41:0] expect_out(logic [12:0] a, logic w,
                                             logic [7:0] romd, logic [7:0] ramd);
    logic rs, as, we;
    logic [7:0] rd;
    logic [15:0] ra;
    logic [14:0] aa;
    int s;
    rs = 0; as = 0; we = 0; rd = 8'hFF; ra = '0; aa = '0;
    if (a[12]) begin
      if (!w) begin
        s = int'(a[11:9]);
        if (mkind[s] == 1) begin
          rs = 1; rd = romd; ra = {mbank[s][5:0], a[9:0]};
        end else if (mkind[s] == 2) begin
          as = 1; rd = ramd; aa = {mbank[s][5:0], a[8:0]};
        end
      end else if (a[11]) begin
        s = int'(a[10:9]);
        if (mkind[s] == 2) begin
          as = 1; we = 1; aa = {mbank[s][5:0], a[8:0]};
        end
      end
    end
    return {rs, as, we, rd, ra, aa};
  endfunction

  function automatic string tag_of(logic [12:0] a, logic w);
    if (!a[12]) return w ? "R9" : "R2";
    if (w) return a[11] ? "R6" : "R7";
    if (a[11]) return "R8";
    return "R11";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      mkind[i] = (i >= 6) ? 1 : 0;
      mbank[i] = 0;
    end
  endtask

  task automatic apply(input logic [12:0] a, input logic w, input logic [7:0] d,
                       input string tag);
    logic [41:0] exp_v, act_v;
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_wdata = d;
    rom_rdata = 8'($urandom); ram_rdata = 8'($urandom);
    #1;
    exp_v = expect_out(a, w, rom_rdata, ram_rdata);
    act_v = {rom_sel, ram_sel, ram_we, cpu_rdata,
             rom_sel ? rom_addr : 16'h0, ram_sel ? ram_addr : 15'h0};
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0b: got %h expected %h", tag, a, w, act_v, exp_v);
    end
    if (w && a == 13'h003F) begin
      mkind[2*d[7:6]] = 1; mkind[2*d[7:6]+1] = 1;
      mbank[2*d[7:6]] = d[5:0]; mbank[2*d[7:6]+1] = d[5:0];
    end else if (w && a == 13'h003E) begin
      mkind[d[7:6]] = 2; mbank[d[7:6]] = d[5:0];
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    apply(13'h1C05, 0, 8'h00, "R1");
    apply(13'h1FFF, 0, 8'h00, "R1");
    apply(13'h1000, 0, 8'h00, "R1");
    apply(13'h1600, 0, 8'h00, "R10");
    apply(13'h0800, 0, 8'h00, "R2");
    apply(13'h003F, 1, 8'h05, "R3");
    apply(13'h1234, 0, 8'h00, "R3");
    apply(13'h1034, 0, 8'h00, "R3");
    apply(13'h003E, 1, 8'h4A, "R4");
    apply(13'h1200, 0, 8'h00, "R4");
    apply(13'h1100, 0, 8'h00, "R4");
    apply(13'h1A10, 1, 8'h77, "R6");
    apply(13'h1810, 1, 8'h77, "R7");
    apply(13'h1210, 1, 8'h77, "R7");
    apply(13'h1A10, 0, 8'h00, "R8");
    apply(13'h1E00, 0, 8'h00, "R8");
    apply(13'h003F, 1, 8'h07, "R5");
    apply(13'h1200, 0, 8'h00, "R5");
    apply(13'h1A00, 1, 8'h11, "R5");
    apply(13'h0040, 1, 8'hFF, "R9");
    apply(13'h1C00, 0, 8'h00, "R9");
    apply(13'h003E, 1, 8'h00, "R4");
    apply(13'h003E, 1, 8'h41, "R4");
    apply(13'h003E, 1, 8'h82, "R4");
    apply(13'h003E, 1, 8'hC3, "R4");
    apply(13'h17FF, 0, 8'h00, "R11");
    apply(13'h1FFF, 1, 8'h5A, "R6");
    for (int n = 0; n < 4000; n++) begin
      int pick;
      logic [12:0] a;
      logic w;
      pick = int'($urandom_range(0, 15));
      if (pick == 0) apply(13'h003F, 1, 8'($urandom), "R3");
      else if (pick == 1) apply(13'h003E, 1, 8'($urandom), "R4");
      else begin
        a = 13'($urandom);
        if (pick > 3) a[12] = 1'b1;
        w = 1'($urandom);
        apply(a, w, 8'($urandom), tag_of(a, w));
      end
    end
    @(negedge clk);
    cpu_wr = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule